// File: doc/BRIEF.md
# Secure Memory Cipher Sequencer

This block drives a block cipher over a range of two on-chip RAMs. One RAM (red) holds plaintext and the other (black) holds ciphertext. Software writes the start block index for each RAM, a length register, a 64-bit chaining value and the mode bits. A start command then makes the sequencer walk the range one block at a time. For each block it offers the data to an external cipher engine over a request/acknowledge port, writes the engine's answer into the opposite RAM, and, in chaining mode, carries the chaining value forward. When the last block is stored it raises a done flag and a maskable interrupt. The same unit can also wipe both RAMs to zero on request.

The engine and the key store sit outside the block. A single input reports that the security monitor is blocking operation. Software reaches registers and RAM contents through one word-addressed bus. Bits 9:8 of the address select a space: 0 is registers, 1 is the red RAM window, 2 is the black RAM window. In a RAM window, word address 2b holds the low 32 bits of block b and word 2b+1 holds the high 32 bits.

Top module: `scm_cipher_seq`

## Requirements
- R1: Registers sit at word offsets 0x00 red start, 0x01 black start, 0x02 length, 0x03 control, 0x04 status, 0x05 error clear, 0x06 interrupt control, 0x07 configuration, 0x08 and 0x09 chaining value low and high. A write to control with bit 2 set launches a run, with bit 1 selecting chaining mode and bit 0 selecting decryption. While the run is active, status bit 2 (ciphering) and bit 0 (busy) read 1 and the engine request stays high with stable data until it is acknowledged.
- R2: Encryption reads len+1 consecutive blocks of the red RAM from the red start index, passes each through the engine, and stores the results into the black RAM from the black start index.
- R3: Decryption reads the black RAM from the black start index and writes the red RAM from the red start index. The engine's decrypt output is high for the whole run.
- R4: In chaining-mode encryption each block is XORed with the chaining value before it goes to the engine. The engine result becomes the new chaining value, so after the run the value registers hold the last ciphertext block.
- R5: In chaining-mode decryption each engine result is XORed with the chaining value to give plaintext. The ciphertext block just consumed becomes the new chaining value, so after the run it is the last ciphertext block. In plain block mode the chaining value is left unchanged.
- R6: If start index plus length reaches or passes the block count of either RAM, the start is refused. Status bit 12 (length error) then becomes 1 and no RAM block changes. A range that ends on the last block is accepted.
- R7: While the monitor-blocked input is high, status bit 3 reads 1, bit 11 reads 0, and a start command is refused without touching the RAMs or the error flags.
- R8: Status bit 8 (interrupt pending) sets when a run or a wipe ends and stays set until a write to interrupt control with bit 1 set. The interrupt output equals pending AND NOT the mask held in interrupt-control bit 0.
- R9: A write to interrupt control with bit 2 set, while idle, wipes every block of both RAMs to zero. Status bit 1 (zeroizing) reads 1 during the wipe, and bit 9 (zeroize done) reads 1 after it.
- R10: A start or wipe command issued while busy is ignored and sets status bit 6 (internal error). Any write to the error-clear register clears bits 6 and 12.
- R11: The configuration register is read-only. It reads bytes per block in bits 6:0, red block count in bits 16:7 and black block count in bits 26:17.
- R12: Status bit 10 (ciphering done) sets when a run stores its last block and clears when the next run is accepted.
- R13: After reset the status word reads 0x800 when not blocked, the interrupt output and the engine request are low, and the interrupt mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 10 | Word address: space in 9:8, offset in 7:0 |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, combinational from address |
| monitor_blocked_i | input | 1 | Security monitor blocks operation |
| cph_req_o | output | 1 | Engine request, held until acknowledged |
| cph_dec_o | output | 1 | Engine direction, 1 = decrypt |
| cph_data_o | output | 64 | Block offered to the engine |
| cph_ack_i | input | 1 | Engine acknowledge, one cycle |
| cph_data_i | input | 64 | Engine result, valid with acknowledge |
| irq_o | output | 1 | Interrupt, pending and unmasked |

## Verification
The hardest state to reach from the ports is a second command arriving while a run is still moving through the RAMs. The bench starts a full-length run against an engine model with random latency, then issues a conflicting start and checks two things: the internal-error flag is raised, and the final RAM image matches the first run alone. The length-limit edge is driven directly with ranges that end exactly on the last block and one block past it, in each RAM separately. Random runs mix modes, offsets and lengths, and chaining values are read back to confirm the carried value.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int ADDR_W = 10;
  localparam int BLK_W  = 64;

  localparam logic [7:0] REG_RED_START   = 8'h00;
  localparam logic [7:0] REG_BLACK_START = 8'h01;
  localparam logic [7:0] REG_LENGTH      = 8'h02;
  localparam logic [7:0] REG_CTRL        = 8'h03;
  localparam logic [7:0] REG_STATUS      = 8'h04;
  localparam logic [7:0] REG_ERR_CLR     = 8'h05;
  localparam logic [7:0] REG_INT_CTRL    = 8'h06;
  localparam logic [7:0] REG_CFG         = 8'h07;
  localparam logic [7:0] REG_IV_LO       = 8'h08;
  localparam logic [7:0] REG_IV_HI       = 8'h09;

  localparam logic [1:0] SPACE_REGS = 2'd0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_REQ   = 2'd2,
    SQ_ZERO  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/scm_ram.sv
module scm_ram #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int BLK_W = 64
) (
  input  logic             clk_i,
  input  logic             seq_we_i,
  input  logic [IDX_W-1:0] seq_idx_i,
  input  logic [BLK_W-1:0] seq_wdata_i,
  output logic [BLK_W-1:0] seq_rdata_o,
  input  logic             bus_we_i,
  input  logic [IDX_W:0]   bus_word_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o
);
  logic [BLK_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] bus_blk;
  logic             bus_half;
  logic [BLK_W-1:0] bus_sel;

  assign bus_blk  = bus_word_i[IDX_W:1];
  assign bus_half = bus_word_i[0];

  always_ff @(posedge clk_i) begin
    if (bus_we_i && int'(bus_blk) < DEPTH) begin
      if (bus_half) mem[bus_blk][63:32] <= bus_wdata_i;
      else          mem[bus_blk][31:0]  <= bus_wdata_i;
    end
    // sequencer port wins on a shared cycle
    if (seq_we_i && int'(seq_idx_i) < DEPTH) mem[seq_idx_i] <= seq_wdata_i;
  end

  always_comb begin
    seq_rdata_o = (int'(seq_idx_i) < DEPTH) ? mem[seq_idx_i] : '0;
    bus_sel     = (int'(bus_blk) < DEPTH) ? mem[bus_blk] : '0;
    bus_rdata_o = bus_half ? bus_sel[63:32] : bus_sel[31:0];
  end
endmodule

// File: rtl/scm_seq.sv
module scm_seq
  import scm_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 16,
  parameter int MAXB  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic             cbc_i,
  input  logic             dec_i,
  input  logic [IDX_W-1:0] red_start_i,
  input  logic [IDX_W-1:0] black_start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             iv_we_lo_i,
  input  logic             iv_we_hi_i,
  input  logic [31:0]      iv_wdata_i,
  input  logic [BLK_W-1:0] red_rdata_i,
  input  logic [BLK_W-1:0] black_rdata_i,
  output logic             red_we_o,
  output logic             black_we_o,
  output logic [IDX_W-1:0] red_idx_o,
  output logic [IDX_W-1:0] black_idx_o,
  output logic [BLK_W-1:0] wdata_o,
  output logic             cph_req_o,
  output logic             cph_dec_o,
  output logic [BLK_W-1:0] cph_data_o,
  input  logic             cph_ack_i,
  input  logic [BLK_W-1:0] cph_data_i,
  output logic [BLK_W-1:0] iv_o,
  output logic             ciphering_o,
  output logic             zeroizing_o,
  output logic             ciph_done_o,
  output logic             zero_done_o
);
  localparam logic [IDX_W-1:0] ZERO_LAST = IDX_W'(MAXB - 1);

  sq_state_e        state_q;
  logic [IDX_W-1:0] red_ptr_q, black_ptr_q;
  logic [LEN_W-1:0] cnt_q;
  logic [BLK_W-1:0] din_q, src_q, iv_q;
  logic [BLK_W-1:0] src_blk, res;
  logic             fire, last;

  always_comb begin
    src_blk     = dec_i ? black_rdata_i : red_rdata_i;
    res         = (cbc_i && dec_i) ? (cph_data_i ^ iv_q) : cph_data_i;
    fire        = (state_q == SQ_REQ) && cph_ack_i;
    last        = (cnt_q == '0);
    red_we_o    = (state_q == SQ_ZERO) || (fire && dec_i);
    black_we_o  = (state_q == SQ_ZERO) || (fire && !dec_i);
    wdata_o     = (state_q == SQ_ZERO) ? '0 : res;
    red_idx_o   = red_ptr_q;
    black_idx_o = black_ptr_q;
    cph_req_o   = (state_q == SQ_REQ);
    cph_dec_o   = dec_i;
    cph_data_o  = din_q;
    iv_o        = iv_q;
    ciphering_o = (state_q == SQ_FETCH) || (state_q == SQ_REQ);
    zeroizing_o = (state_q == SQ_ZERO);
    ciph_done_o = fire && last;
    zero_done_o = (state_q == SQ_ZERO) && (red_ptr_q == ZERO_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_IDLE;
      red_ptr_q   <= '0;
      black_ptr_q <= '0;
      cnt_q       <= '0;
      din_q       <= '0;
      src_q       <= '0;
      iv_q        <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (iv_we_lo_i) iv_q[31:0]  <= iv_wdata_i;
          if (iv_we_hi_i) iv_q[63:32] <= iv_wdata_i;
          if (zero_i) begin
            red_ptr_q   <= '0;
            black_ptr_q <= '0;
            state_q     <= SQ_ZERO;
          end else if (start_i) begin
            red_ptr_q   <= red_start_i;
            black_ptr_q <= black_start_i;
            cnt_q       <= len_i;
            state_q     <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          din_q   <= (cbc_i && !dec_i) ? (src_blk ^ iv_q) : src_blk;
          src_q   <= src_blk;
          state_q <= SQ_REQ;
        end
        SQ_REQ: begin
          if (cph_ack_i) begin
            if (cbc_i) iv_q <= dec_i ? src_q : cph_data_i;
            if (last) begin
              state_q <= SQ_IDLE;
            end else begin
              cnt_q       <= cnt_q - LEN_W'(1);
              red_ptr_q   <= red_ptr_q + IDX_W'(1);
              black_ptr_q <= black_ptr_q + IDX_W'(1);
              state_q     <= SQ_FETCH;
            end
          end
        end
        SQ_ZERO: begin
          red_ptr_q   <= red_ptr_q + IDX_W'(1);
          black_ptr_q <= black_ptr_q + IDX_W'(1);
          if (red_ptr_q == ZERO_LAST) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scm_cipher_seq.sv
module scm_cipher_seq
  import scm_pkg::*;
#(
  parameter int RED_BLOCKS   = 16,
  parameter int BLACK_BLOCKS = 16,
  parameter int BLK_BYTES    = 8,
  parameter int LEN_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              monitor_blocked_i,
  output logic              cph_req_o,
  output logic              cph_dec_o,
  output logic [BLK_W-1:0]  cph_data_o,
  input  logic              cph_ack_i,
  input  logic [BLK_W-1:0]  cph_data_i,
  output logic              irq_o
);
  localparam int MAXB  = (RED_BLOCKS > BLACK_BLOCKS) ? RED_BLOCKS : BLACK_BLOCKS;
  localparam int IDX_W = (MAXB > 1) ? $clog2(MAXB) : 1;

  logic [LEN_W-1:0] red_start_q, black_start_q, len_q;
  logic             cbc_q, dec_q, mask_q;
  logic             len_err_q, int_err_q, cdone_q, zdone_q, pend_q;
  logic             ciphering, zeroizing, busy;
  logic             ciph_done, zero_done;
  logic [BLK_W-1:0] iv;
  logic [31:0]      status_w, cfg_w;

  logic [7:0]       reg_off;
  logic             reg_wr, ctrl_wr, int_wr, start_req, zero_req, len_bad, start_ok, zero_ok;

  // side 0 = red, side 1 = black
  logic [1:0]       side_seq_we, side_bus_we, side_bus_ok;
  logic [IDX_W-1:0] side_idx [2];
  logic [BLK_W-1:0] side_rd [2];
  logic [31:0]      side_bus_rd [2];
  logic [BLK_W-1:0] seq_wdata;

  assign reg_off   = bus_addr_i[7:0];
  assign reg_wr    = bus_we_i && (bus_addr_i[9:8] == SPACE_REGS);
  assign ctrl_wr   = reg_wr && (reg_off == REG_CTRL);
  assign int_wr    = reg_wr && (reg_off == REG_INT_CTRL);
  assign start_req = ctrl_wr && bus_wdata_i[2];
  assign zero_req  = int_wr && bus_wdata_i[2];
  assign busy      = ciphering || zeroizing;
  assign len_bad   = (int'(red_start_q) + int'(len_q) >= RED_BLOCKS) ||
                     (int'(black_start_q) + int'(len_q) >= BLACK_BLOCKS);
  assign start_ok  = start_req && !busy && !monitor_blocked_i && !len_bad;
  assign zero_ok   = zero_req && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_start_q   <= '0;
      black_start_q <= '0;
      len_q         <= '0;
      cbc_q         <= 1'b0;
      dec_q         <= 1'b0;
      mask_q        <= 1'b0;
      len_err_q     <= 1'b0;
      int_err_q     <= 1'b0;
      cdone_q       <= 1'b0;
      zdone_q       <= 1'b0;
      pend_q        <= 1'b0;
    end else begin
      if (reg_wr && !busy) begin
        if (reg_off == REG_RED_START)   red_start_q   <= bus_wdata_i[LEN_W-1:0];
        if (reg_off == REG_BLACK_START) black_start_q <= bus_wdata_i[LEN_W-1:0];
        if (reg_off == REG_LENGTH)      len_q         <= bus_wdata_i[LEN_W-1:0];
        if (reg_off == REG_CTRL) begin
          cbc_q <= bus_wdata_i[1];
          dec_q <= bus_wdata_i[0];
        end
      end
      if (int_wr) mask_q <= bus_wdata_i[0];

      if (reg_wr && reg_off == REG_ERR_CLR) begin
        len_err_q <= 1'b0;
        int_err_q <= 1'b0;
      end else begin
        if (start_req && !busy && !monitor_blocked_i && len_bad) len_err_q <= 1'b1;
        if ((start_req || zero_req) && busy) int_err_q <= 1'b1;
      end

      if (ciph_done)     cdone_q <= 1'b1;
      else if (start_ok) cdone_q <= 1'b0;
      if (zero_done)     zdone_q <= 1'b1;
      else if (zero_ok)  zdone_q <= 1'b0;

      if (ciph_done || zero_done)     pend_q <= 1'b1;
      else if (int_wr && bus_wdata_i[1]) pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q && !mask_q;

  assign status_w = {19'b0, len_err_q, !monitor_blocked_i, cdone_q, zdone_q, pend_q,
                     1'b0, int_err_q, 1'b0, 1'b0, monitor_blocked_i,
                     ciphering, zeroizing, busy};
  assign cfg_w    = {5'b0, 10'(BLACK_BLOCKS), 10'(RED_BLOCKS), 7'(BLK_BYTES)};

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i[9:8])
      2'd0: begin
        unique case (reg_off)
          REG_RED_START:   bus_rdata_o = 32'(red_start_q);
          REG_BLACK_START: bus_rdata_o = 32'(black_start_q);
          REG_LENGTH:      bus_rdata_o = 32'(len_q);
          REG_CTRL:        bus_rdata_o = {29'b0, ciphering, cbc_q, dec_q};
          REG_STATUS:      bus_rdata_o = status_w;
          REG_INT_CTRL:    bus_rdata_o = {31'b0, mask_q};
          REG_CFG:         bus_rdata_o = cfg_w;
          REG_IV_LO:       bus_rdata_o = iv[31:0];
          REG_IV_HI:       bus_rdata_o = iv[63:32];
          default:         bus_rdata_o = '0;
        endcase
      end
      2'd1:    bus_rdata_o = side_bus_ok[0] ? side_bus_rd[0] : '0;
      2'd2:    bus_rdata_o = side_bus_ok[1] ? side_bus_rd[1] : '0;
      default: bus_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_side
    localparam int SIDE_DEPTH = (g == 0) ? RED_BLOCKS : BLACK_BLOCKS;

    assign side_bus_ok[g] = (int'(bus_addr_i[7:1]) < SIDE_DEPTH);
    assign side_bus_we[g] = bus_we_i && !busy && side_bus_ok[g] &&
                            (bus_addr_i[9:8] == 2'(g + 1));

    scm_ram #(
      .DEPTH(SIDE_DEPTH),
      .IDX_W(IDX_W),
      .BLK_W(BLK_W)
    ) i_ram (
      .clk_i      (clk_i),
      .seq_we_i   (side_seq_we[g]),
      .seq_idx_i  (side_idx[g]),
      .seq_wdata_i(seq_wdata),
      .seq_rdata_o(side_rd[g]),
      .bus_we_i   (side_bus_we[g]),
      .bus_word_i (bus_addr_i[IDX_W:0]),
      .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(side_bus_rd[g])
    );
  end

  scm_seq #(
    .IDX_W(IDX_W),
    .LEN_W(LEN_W),
    .MAXB (MAXB)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_ok),
    .zero_i       (zero_ok),
    .cbc_i        (cbc_q),
    .dec_i        (dec_q),
    .red_start_i  (red_start_q[IDX_W-1:0]),
    .black_start_i(black_start_q[IDX_W-1:0]),
    .len_i        (len_q),
    .iv_we_lo_i   (reg_wr && !busy && reg_off == REG_IV_LO),
    .iv_we_hi_i   (reg_wr && !busy && reg_off == REG_IV_HI),
    .iv_wdata_i   (bus_wdata_i),
    .red_rdata_i  (side_rd[0]),
    .black_rdata_i(side_rd[1]),
    .red_we_o     (side_seq_we[0]),
    .black_we_o   (side_seq_we[1]),
    .red_idx_o    (side_idx[0]),
    .black_idx_o  (side_idx[1]),
    .wdata_o      (seq_wdata),
    .cph_req_o    (cph_req_o),
    .cph_dec_o    (cph_dec_o),
    .cph_data_o   (cph_data_o),
    .cph_ack_i    (cph_ack_i),
    .cph_data_i   (cph_data_i),
    .iv_o         (iv),
    .ciphering_o  (ciphering),
    .zeroizing_o  (zeroizing),
    .ciph_done_o  (ciph_done),
    .zero_done_o  (zero_done)
  );
endmodule

// File: rtl/scm_cipher_seq_chk.sv
module scm_cipher_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_o,
  input logic        cph_req_o,
  input logic        cph_ack_i,
  input logic [63:0] cph_data_o,
  input logic        monitor_blocked_i,
  input logic [31:0] status_i
);
  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cph_req_o && !cph_ack_i |=> cph_req_o && $stable(cph_data_o));

  a_r1_req_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cph_req_o |-> status_i[2] && status_i[0]);

  a_r8_irq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_i[8]);

  a_r9_wipe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_i[1] && status_i[2]));

  a_r12_done_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[2]) |-> status_i[10] && status_i[8]);

  a_r7_no_start_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    monitor_blocked_i && !status_i[0] |=> !status_i[2]);
endmodule

bind scm_cipher_seq scm_cipher_seq_chk i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .irq_o            (irq_o),
  .cph_req_o        (cph_req_o),
  .cph_ack_i        (cph_ack_i),
  .cph_data_o       (cph_data_o),
  .monitor_blocked_i(monitor_blocked_i),
  .status_i         (status_w)
);

// File: tb/test_scm_cipher_seq.sv
`timescale 1ns/1ps
module test_scm_cipher_seq;
  localparam int NB = 16;
  localparam logic [63:0] KEY = 64'h0F1E_2D3C_4B5A_6978;
  localparam logic [9:0] A_RS = 10'h000, A_BS = 10'h001, A_LEN = 10'h002, A_CTRL = 10'h003,
                         A_ST = 10'h004, A_ECLR = 10'h005, A_INT = 10'h006, A_CFG = 10'h007,
                         A_IVL = 10'h008, A_IVH = 10'h009;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        blocked = 1'b0;
  logic        cph_req, cph_dec, cph_ack = 1'b0;
  logic [63:0] cph_dout, cph_din = '0;
  logic        irq;

  int nvec = 0, nerr = 0;
  bit finished = 0;
  logic [63:0] ref_red [NB];
  logic [63:0] ref_black [NB];
  logic [63:0] ref_iv = '0;

  always #2 clk = ~clk;

  scm_cipher_seq i_scm_cipher_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .monitor_blocked_i(blocked),
    .cph_req_o(cph_req), .cph_dec_o(cph_dec), .cph_data_o(cph_dout),
    .cph_ack_i(cph_ack), .cph_data_i(cph_din), .irq_o(irq));

  function automatic logic [63:0] eng_enc(logic [63:0] x);
    return {x[50:0], x[63:51]} ^ KEY;
  endfunction
  function automatic logic [63:0] eng_dec(logic [63:0] y);
    logic [63:0] z = y ^ KEY;
    return {z[12:0], z[63:13]};
  endfunction

  // engine model with random latency
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      cph_ack = 1'b0;
      if (cph_req) begin
        if (dly == 0) begin
          cph_ack = 1'b1;
          cph_din = cph_dec ? eng_dec(cph_dout) : eng_enc(cph_dout);
          dly = int'($urandom % 4);
        end else dly--;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(A_ST, s);
      if (!s[0]) return;
    end
    chk({tag, " idle timeout"}, 64'(s[0]), 64'd0);
  endtask

  task automatic cmp_rams(input string tag);
    logic [31:0] lo, hi;
    for (int b = 0; b < NB; b++) begin
      rd(10'h100 + 10'(2*b), lo); rd(10'h101 + 10'(2*b), hi);
      chk({tag, " red"}, {hi, lo}, ref_red[b]);
      rd(10'h200 + 10'(2*b), lo); rd(10'h201 + 10'(2*b), hi);
      chk({tag, " black"}, {hi, lo}, ref_black[b]);
    end
  endtask

  task automatic model(input bit dec, input bit cbc, input int rs, input int bs, input int len);
    logic [63:0] p, c, d;
    for (int i = 0; i <= len; i++) begin
      if (!dec) begin
        p = ref_red[rs+i];
        c = eng_enc(cbc ? (p ^ ref_iv) : p);
        ref_black[bs+i] = c;
        if (cbc) ref_iv = c;
      end else begin
        c = ref_black[bs+i];
        d = eng_dec(c);
        ref_red[rs+i] = cbc ? (d ^ ref_iv) : d;
        if (cbc) ref_iv = c;
      end
    end
  endtask

  task automatic run_op(input string tag, input bit dec, input bit cbc,
                        input int rs, input int bs, input int len);
    logic [31:0] s, lo, hi;
    logic [63:0] ivr;
    wr(A_INT, 32'h2);
    wr(A_RS, 32'(rs)); wr(A_BS, 32'(bs)); wr(A_LEN, 32'(len));
    ivr = {$urandom, $urandom};
    wr(A_IVL, ivr[31:0]); wr(A_IVH, ivr[63:32]);
    ref_iv = ivr;
    wr(A_CTRL, 32'(4 | (cbc << 1) | dec));
    model(dec, cbc, rs, bs, len);
    rd(A_ST, s);
    chk({tag, " R1 ciphering+busy"}, 64'({s[2], s[0]}), 64'b11);
    chk({tag, " R12 done cleared at start"}, 64'(s[10]), 64'd0);
    chk({tag, " R3 engine dir"}, 64'(cph_dec), 64'(dec));
    wait_idle(tag);
    rd(A_ST, s);
    chk({tag, " R12 done set / R8 pending"}, 64'({s[10], s[8], s[2]}), 64'b110);
    chk({tag, " R8 irq"}, 64'(irq), 64'd1);
    cmp_rams({tag, (dec ? " R3" : " R2")});
    rd(A_IVL, lo); rd(A_IVH, hi);
    chk({tag, (dec ? " R5 iv" : " R4 iv")}, {hi, lo}, ref_iv);
  endtask

  initial begin
    logic [31:0] s, v;
    void'($urandom(32'h5EC0_0DE5));
    #10 rst_n = 1'b1;

    // R13 / R11
    rd(A_ST, s);   chk("R13 status", 64'(s), 64'h800);
    chk("R13 irq/req", 64'({irq, cph_req}), 64'd0);
    rd(A_INT, s);  chk("R13 mask", 64'(s), 64'd0);
    rd(A_CFG, s);  chk("R11 cfg", 64'(s), 64'((16 << 17) | (16 << 7) | 8));
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, s);  chk("R11 cfg read-only", 64'(s), 64'((16 << 17) | (16 << 7) | 8));

    for (int b = 0; b < NB; b++) begin
      ref_red[b] = {$urandom, $urandom};
      ref_black[b] = {$urandom, $urandom};
      wr(10'h100 + 10'(2*b), ref_red[b][31:0]);   wr(10'h101 + 10'(2*b), ref_red[b][63:32]);
      wr(10'h200 + 10'(2*b), ref_black[b][31:0]); wr(10'h201 + 10'(2*b), ref_black[b][63:32]);
    end
    cmp_rams("load");

    run_op("ecb enc single", 0, 0, 0, 0, 0);
    run_op("ecb enc offset", 0, 0, 3, 5, 7);
    run_op("ecb dec", 1, 0, 2, 1, 9);
    run_op("cbc enc", 0, 1, 0, 4, 11);
    run_op("cbc dec", 1, 1, 4, 0, 11);
    run_op("R6 last block ok", 0, 1, 15, 15, 0);

    for (int k = 0; k < 20; k++) begin
      int len = int'($urandom % NB);
      int rs  = int'($urandom % (NB - len));
      int bs  = int'($urandom % (NB - len));
      run_op("rand", bit'($urandom % 2), bit'($urandom % 2), rs, bs, len);
    end

    // R6 length errors, red and black sides
    wr(A_INT, 32'h2);
    wr(A_RS, 32'd15); wr(A_BS, 32'd0); wr(A_LEN, 32'd1);
    wr(A_CTRL, 32'h4);
    rd(A_ST, s); chk("R6 red overrun", 64'({s[12], s[8], s[0]}), 64'b100);
    wr(A_ECLR, 32'h0);
    rd(A_ST, s); chk("R10 clear len err", 64'(s[12]), 64'd0);
    wr(A_RS, 32'd0); wr(A_BS, 32'd10); wr(A_LEN, 32'd6);
    wr(A_CTRL, 32'h5);
    rd(A_ST, s); chk("R6 black overrun", 64'({s[12], s[8], s[0]}), 64'b100);
    cmp_rams("R6 unchanged");
    wr(A_ECLR, 32'h0);

    // R7 monitor blocking
    blocked = 1'b1;
    wr(A_RS, 32'd0); wr(A_BS, 32'd0); wr(A_LEN, 32'd3);
    rd(A_ST, s); chk("R7 blocked bits", 64'({s[11], s[3]}), 64'b01);
    wr(A_CTRL, 32'h4);
    rd(A_ST, s); chk("R7 start refused", 64'({s[12], s[6], s[2], s[0]}), 64'd0);
    cmp_rams("R7 unchanged");
    blocked = 1'b0;
    rd(A_ST, s); chk("R7 unblocked", 64'({s[11], s[3]}), 64'b10);

    // R10 start while busy
    wr(A_INT, 32'h2);
    wr(A_RS, 32'd0); wr(A_BS, 32'd0); wr(A_LEN, 32'd15);
    wr(A_CTRL, 32'h4);
    model(0, 0, 0, 0, 15);
    wr(A_CTRL, 32'h7);
    rd(A_ST, s); chk("R10 busy start flagged", 64'({s[6], s[0]}), 64'b11);
    wr(10'h100, 32'hDEAD_BEEF);
    wait_idle("R10");
    cmp_rams("R10 first run only");
    rd(A_CTRL, s); chk("R10 mode kept", 64'(s), 64'd0);
    wr(A_ECLR, 32'h0);
    rd(A_ST, s); chk("R10 clear int err", 64'(s[6]), 64'd0);

    // R8 masking and clearing
    rd(A_ST, s); chk("R8 pending after run", 64'({s[8], irq}), 64'b11);
    wr(A_INT, 32'h1);
    rd(A_ST, s); chk("R8 masked", 64'({s[8], irq}), 64'b10);
    wr(A_INT, 32'h0);
    rd(A_ST, s); chk("R8 unmasked", 64'({s[8], irq}), 64'b11);
    wr(A_INT, 32'h2);
    rd(A_ST, s); chk("R8 cleared", 64'({s[8], irq}), 64'b00);

    // R9 wipe
    wr(A_INT, 32'h4);
    rd(A_ST, s); chk("R9 zeroizing", 64'({s[2], s[1], s[0]}), 64'b011);
    wr(A_INT, 32'h4);
    rd(A_ST, s); chk("R10 wipe while busy", 64'(s[6]), 64'd1);
    wait_idle("R9");
    rd(A_ST, s); chk("R9 done+pending", 64'({s[9], s[8], s[1]}), 64'b110);
    for (int b = 0; b < NB; b++) begin ref_red[b] = '0; ref_black[b] = '0; end
    cmp_rams("R9 wiped");
    wr(A_ECLR, 32'h0);
    rd(A_IVL, v);

    run_op("post wipe", 0, 1, 1, 2, 4);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule